// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns packets that a host writes, one byte at a time, into a bit-serial HDLC stream. The host pushes bytes into a 256-entry transmit queue and marks the last byte of each packet. The framer sends each packet in this order: an opening flag, the payload with zero-bit insertion, a 16-bit frame check sequence, and a closing flag. When no packet is ready, the line carries a fill byte. Each byte on the line goes out least-significant bit first. The line advances by one bit for each cycle in which the bit-enable strobe is high.

Three test and maintenance switches change the frame. One drops the check sequence. One turns zero insertion off. One sends the check sequence inverted. If the queue runs dry in the middle of a packet, the framer sends an abort byte and latches an underrun flag. It then sends only fill until the host pulses the transmit reset. The host can watch the queue through a live fill count and a low-watermark flag whose threshold it selects. A one-cycle pulse marks the end of each packet on the line.

Top module: `hdlc_tx_framer`

## Requirements
- R1: The queue holds 256 bytes, each stored with an end-of-packet bit. `fillLevel` always shows the number of bytes queued. A write to a full queue is dropped, and it sets `overflow`, which stays set until transmit reset.
- R2: After reset or transmit reset the first byte sent is 7Eh. When the queue is not empty at a byte boundary, the framer sends an opening 7Eh. The payload bytes follow in write order, then the closing 7Eh. Every byte is sent LSB first.
- R3: Between the opening and closing flags, including the check sequence, a 0 is inserted after every run of five 1s. The run count restarts at each opening flag. Flags, fill and abort bytes are never stuffed. With `stuffDefeat`=1 no 0 is ever inserted.
- R4: With `crcDefeat`=0 the framer appends a check sequence after the payload, low byte first. It is computed with x^16+x^12+x^5+1, LSB first, preset FFFFh, and the ones-complement of the register is sent. With `crcDefeat`=1 the closing flag directly follows the payload.
- R5: With `crcInvert`=1 all 16 bits of the check sequence are sent inverted. When `crcDefeat`=1, `crcInvert` has no effect.
- R6: Between packets the line carries 7Eh when `fillSel`=0 and FFh when `fillSel`=1.
- R7: When the queue is empty at a byte boundary inside a packet, the framer sends FEh and then only fill bytes, and it sets `underrun`, which stays set.
- R8: After an underrun, queued packets are not sent and the queue is not drained until `txReset`. `txReset` empties the queue and clears `underrun` and `overflow`.
- R9: `pktEnd` is high for one cycle, together with the last bit of each closing flag on `txBit`.
- R10: `lowMark` is 1 exactly when `fillLevel` < (`lowMarkSel`+1)*32.
- R11: `txBit` changes only in the cycle after a cycle with `bitEn`=1. After reset it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txReset | input | 1 | Synchronous transmit reset: clears the queue, flags and framer |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Byte to queue |
| wrEop | input | 1 | The written byte ends its packet |
| crcDefeat | input | 1 | 1 = no check sequence |
| stuffDefeat | input | 1 | 1 = no zero insertion |
| crcInvert | input | 1 | 1 = send the check sequence inverted |
| fillSel | input | 1 | Fill between packets: 0 = 7Eh, 1 = FFh |
| lowMarkSel | input | 3 | Low-watermark threshold select |
| bitEn | input | 1 | Advance the line by one bit |
| txBit | output | 1 | Serial line data |
| pktEnd | output | 1 | Pulse on the last bit of a closing flag |
| underrun | output | 1 | Sticky mid-packet queue starvation |
| overflow | output | 1 | Sticky write-to-full |
| lowMark | output | 1 | Fill level below threshold |
| fillLevel | output | 9 | Bytes in the queue |

## Verification
The embedded assertions check on every cycle that the fill count stays within the queue depth and that both error flags stay latched until transmit reset. They also check that the line bit holds when no strobe arrives, that the stuffing run never goes past five, that the end pulse is one cycle wide, and that the fill-only state is left only through transmit reset. Only the bench's scenarios can show that the serial stream is bit-exact. They compare the stream against a model built from the requirements: the check sequence value, each placement of an inserted zero, the abort sequence, the fill byte choice and the position of the end pulse.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  IDLE_BYTE  = 8'hFF;
  localparam logic [7:0]  ABORT_BYTE = 8'hFE;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;  // x^16+x^12+x^5+1, bit-reflected

  typedef enum logic [2:0] {
    SEL_FILL   = 3'd0,
    SEL_FLAG   = 3'd1,
    SEL_ABORT  = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_FCS_LO = 3'd4,
    SEL_FCS_HI = 3'd5
  } byteSel_e;

  typedef enum logic [2:0] {
    ST_FILL  = 3'd0,
    ST_OPEN  = 3'd1,
    ST_DATA  = 3'd2,
    ST_FCS1  = 3'd3,
    ST_FCS2  = 3'd4,
    ST_CLOSE = 3'd5,
    ST_ABORT = 3'd6,
    ST_DEAD  = 3'd7
  } txState_e;

  typedef struct packed {
    logic     load;     // a new byte enters the shifter
    byteSel_e sel;      // which byte
    logic     stuff;    // byte lies inside the stuffed region
    logic     pop;      // take the queue head
    logic     crcInit;  // preset the check register
    logic     crcUpd;   // fold the queue head into the check register
  } ctrlStrobe_t;

  // Fold one byte, LSB first, into a reflected CRC register.
  function automatic logic [15:0] crcFold(input logic [15:0] crcIn, input logic [7:0] din);
    logic [15:0] acc;
    acc = crcIn;
    for (int k = 0; k < 8; k++) begin
      if (acc[0] ^ din[k]) acc = (acc >> 1) ^ CRC_POLY_R;
      else                 acc = acc >> 1;
    end
    return acc;
  endfunction

endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         wrEn,
  input  logic [WIDTH-1:0]             wrWord,
  input  logic                         rdEn,
  output logic [WIDTH-1:0]             rdWord,
  output logic                         empty,
  output logic [$clog2(DEPTH):0]       level,
  output logic                         overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             full, doWr, doRd;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign doWr   = wrEn && !full && !clr;
  assign doRd   = rdEn && !empty && !clr;
  assign rdWord = mem[rdPtr];
  assign level  = count;

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else if (clr) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (doWr) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doRd) rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      count <= count + (AW+1)'(doWr) - (AW+1)'(doRd);
      if (wrEn && full) overflow <= 1'b1;
    end
  end

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_overflow_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clr |=> overflow);

  p_full_write_dropped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full && wrEn && !rdEn && !clr |=> count == FULL_CNT);

endmodule

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int MARK_LVLS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txReset,
  input  logic                   wrEn,
  input  logic [7:0]             wrData,
  input  logic                   wrEop,
  input  logic                   bitEn,
  input  logic                   stuffDefeat,
  input  logic                   crcInvert,
  input  logic                   fillSel,
  input  logic [2:0]             lowMarkSel,
  input  ctrlStrobe_t            stb,
  output logic                   byteDone,
  output logic                   fifoEmpty,
  output logic                   lastEop,
  output logic                   txBit,
  output logic                   overflow,
  output logic                   lowMark,
  output logic [$clog2(DEPTH):0] fillLevel
);
  localparam int LW        = $clog2(DEPTH) + 1;
  localparam int MARK_STEP = DEPTH / MARK_LVLS;
  localparam logic [2:0] RUN_MAX = 3'd5;

  logic [8:0]    headWord;
  logic [7:0]    shReg, nextByte;
  logic [3:0]    bitsLeft;
  logic [2:0]    onesCnt;
  logic          stuffOn, stuffNow;
  logic [15:0]   crcReg, fcsWord;
  logic [LW-1:0] markThresh;

  hdlc_tx_fifo #(.DEPTH(DEPTH), .WIDTH(9)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (txReset),
    .wrEn     (wrEn),
    .wrWord   ({wrEop, wrData}),
    .rdEn     (stb.pop),
    .rdWord   (headWord),
    .empty    (fifoEmpty),
    .level    (fillLevel),
    .overflow (overflow)
  );

  assign markThresh = LW'((32'(lowMarkSel) + 32'd1) * MARK_STEP);
  assign lowMark    = (fillLevel < markThresh);

  // Check sequence: the normal form is the complement of the register.
  assign fcsWord = crcInvert ? crcReg : ~crcReg;

  always_comb begin
    unique case (stb.sel)
      SEL_FLAG:   nextByte = FLAG_BYTE;
      SEL_ABORT:  nextByte = ABORT_BYTE;
      SEL_DATA:   nextByte = headWord[7:0];
      SEL_FCS_LO: nextByte = fcsWord[7:0];
      SEL_FCS_HI: nextByte = fcsWord[15:8];
      default:    nextByte = fillSel ? IDLE_BYTE : FLAG_BYTE;
    endcase
  end

  assign stuffNow = (onesCnt == RUN_MAX);
  assign byteDone = bitEn && !stuffNow && (bitsLeft == 4'd1);

  // Bit shifter with zero insertion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shReg    <= FLAG_BYTE;
      bitsLeft <= 4'd8;
      onesCnt  <= '0;
      stuffOn  <= 1'b0;
      txBit    <= 1'b1;
    end else if (txReset) begin
      shReg    <= FLAG_BYTE;
      bitsLeft <= 4'd8;
      onesCnt  <= '0;
      stuffOn  <= 1'b0;
      txBit    <= 1'b1;
    end else if (bitEn) begin
      if (stuffNow) begin
        txBit   <= 1'b0;
        onesCnt <= '0;
      end else begin
        txBit   <= shReg[0];
        onesCnt <= (stuffOn && !stuffDefeat && shReg[0]) ? onesCnt + 3'd1 : '0;
        if (byteDone) begin
          shReg    <= nextByte;
          bitsLeft <= 4'd8;
          stuffOn  <= stb.stuff;
        end else begin
          shReg    <= {1'b0, shReg[7:1]};
          bitsLeft <= bitsLeft - 4'd1;
        end
      end
    end
  end

  // Check register and end-of-packet tracking.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crcReg  <= CRC_PRESET;
      lastEop <= 1'b0;
    end else if (txReset) begin
      crcReg  <= CRC_PRESET;
      lastEop <= 1'b0;
    end else begin
      if (stb.crcInit)     crcReg <= CRC_PRESET;
      else if (stb.crcUpd) crcReg <= crcFold(crcReg, headWord[7:0]);
      if (stb.crcInit)  lastEop <= 1'b0;
      else if (stb.pop) lastEop <= headWord[8];
    end
  end

  p_bit_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !bitEn && !txReset |=> $stable(txBit));

  p_run_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    onesCnt <= RUN_MAX);

  p_no_stuff_defeated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stuffDefeat && $stable(stuffDefeat) && onesCnt == '0 && !txReset |=> onesCnt == '0);

  p_pop_needs_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pop |-> !fifoEmpty);

  p_shift_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bitsLeft != 4'd0 && bitsLeft <= 4'd8);

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txReset,
  input  logic        byteDone,
  input  logic        fifoEmpty,
  input  logic        lastEop,
  input  logic        crcDefeat,
  output ctrlStrobe_t stb,
  output logic        pktEnd,
  output logic        underrun
);
  txState_e state, nextState;
  logic     setUnder, endNow;

  always_comb begin
    stb       = '0;
    stb.load  = byteDone;
    stb.sel   = SEL_FILL;
    nextState = state;
    setUnder  = 1'b0;
    endNow    = 1'b0;
    if (byteDone) begin
      unique case (state)
        ST_FILL, ST_CLOSE: begin
          endNow = (state == ST_CLOSE);
          if (!fifoEmpty) begin
            stb.sel     = SEL_FLAG;
            stb.crcInit = 1'b1;
            nextState   = ST_OPEN;
          end else begin
            nextState   = ST_FILL;
          end
        end
        ST_OPEN, ST_DATA: begin
          if (state == ST_DATA && lastEop) begin
            if (crcDefeat) begin
              stb.sel   = SEL_FLAG;
              nextState = ST_CLOSE;
            end else begin
              stb.sel   = SEL_FCS_LO;
              stb.stuff = 1'b1;
              nextState = ST_FCS1;
            end
          end else if (!fifoEmpty) begin
            stb.sel    = SEL_DATA;
            stb.stuff  = 1'b1;
            stb.pop    = 1'b1;
            stb.crcUpd = 1'b1;
            nextState  = ST_DATA;
          end else begin
            stb.sel   = SEL_ABORT;
            setUnder  = 1'b1;
            nextState = ST_ABORT;
          end
        end
        ST_FCS1: begin
          stb.sel   = SEL_FCS_HI;
          stb.stuff = 1'b1;
          nextState = ST_FCS2;
        end
        ST_FCS2: begin
          stb.sel   = SEL_FLAG;
          nextState = ST_CLOSE;
        end
        default: begin
          nextState = ST_DEAD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_FILL;
      pktEnd   <= 1'b0;
      underrun <= 1'b0;
    end else if (txReset) begin
      state    <= ST_FILL;
      pktEnd   <= 1'b0;
      underrun <= 1'b0;
    end else begin
      state  <= nextState;
      pktEnd <= endNow;
      if (setUnder) underrun <= 1'b1;
    end
  end

  p_dead_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DEAD && !txReset |=> state == ST_DEAD);

  p_dead_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DEAD |-> !stb.pop);

  p_underrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    underrun && !txReset |=> underrun);

  p_pktend_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pktEnd |=> !pktEnd);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.crcInit, stb.crcUpd}));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   txReset,
  input  logic                   wrEn,
  input  logic [7:0]             wrData,
  input  logic                   wrEop,
  input  logic                   crcDefeat,
  input  logic                   stuffDefeat,
  input  logic                   crcInvert,
  input  logic                   fillSel,
  input  logic [2:0]             lowMarkSel,
  input  logic                   bitEn,
  output logic                   txBit,
  output logic                   pktEnd,
  output logic                   underrun,
  output logic                   overflow,
  output logic                   lowMark,
  output logic [$clog2(DEPTH):0] fillLevel
);
  ctrlStrobe_t stb;
  logic        byteDone, fifoEmpty, lastEop;

  hdlc_tx_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .txReset   (txReset),
    .byteDone  (byteDone),
    .fifoEmpty (fifoEmpty),
    .lastEop   (lastEop),
    .crcDefeat (crcDefeat),
    .stb       (stb),
    .pktEnd    (pktEnd),
    .underrun  (underrun)
  );

  hdlc_tx_datapath #(.DEPTH(DEPTH), .MARK_LVLS(8)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .txReset     (txReset),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .wrEop       (wrEop),
    .bitEn       (bitEn),
    .stuffDefeat (stuffDefeat),
    .crcInvert   (crcInvert),
    .fillSel     (fillSel),
    .lowMarkSel  (lowMarkSel),
    .stb         (stb),
    .byteDone    (byteDone),
    .fifoEmpty   (fifoEmpty),
    .lastEop     (lastEop),
    .txBit       (txBit),
    .overflow    (overflow),
    .lowMark     (lowMark),
    .fillLevel   (fillLevel)
  );

endmodule

// File: tb/hdlc_tx_framer_tb.sv
module hdlc_tx_framer_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txReset = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrEop = 1'b0;
  logic       crcDefeat = 1'b0, stuffDefeat = 1'b0, crcInvert = 1'b0, fillSel = 1'b0;
  logic [2:0] lowMarkSel = '0;
  logic       bitEn = 1'b0;
  logic       txBit, pktEnd, underrun, overflow, lowMark;
  logic [8:0] fillLevel;

  hdlc_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .txReset(txReset), .wrEn(wrEn), .wrData(wrData),
    .wrEop(wrEop), .crcDefeat(crcDefeat), .stuffDefeat(stuffDefeat),
    .crcInvert(crcInvert), .fillSel(fillSel), .lowMarkSel(lowMarkSel),
    .bitEn(bitEn), .txBit(txBit), .pktEnd(pktEnd), .underrun(underrun),
    .overflow(overflow), .lowMark(lowMark), .fillLevel(fillLevel)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  // Expected stream model
  bit expBits [0:1023];
  int expN, runOnes, closeEnd;

  task automatic pushRaw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      expBits[expN] = b[i];
      expN++;
    end
  endtask

  task automatic pushStuffed(input logic [7:0] b, input bit noStuff);
    for (int i = 0; i < 8; i++) begin
      expBits[expN] = b[i];
      expN++;
      if (b[i]) runOnes++; else runOnes = 0;
      if (runOnes == 5 && !noStuff) begin
        expBits[expN] = 1'b0;
        expN++;
        runOnes = 0;
      end
    end
  endtask

  function automatic logic [15:0] modelCrc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic x;
      x = r[0] ^ b[i];
      r = {1'b0, r[15:1]};
      if (x) r = r ^ 16'h8408;
    end
    return r;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic doTxReset();
    txReset = 1'b1; tick(); txReset = 1'b0;
  endtask

  task automatic writeByte(input logic [7:0] d, input bit eop);
    wrEn = 1'b1; wrData = d; wrEop = eop; tick();
    wrEn = 1'b0; wrEop = 1'b0;
  endtask

  task automatic sendBit(output bit b, output bit pe);
    bitEn = 1'b1; tick(); bitEn = 1'b0;
    b = txBit; pe = pktEnd;
  endtask

  // {len[4:0], base[7:0], step[7:0], crcDefeat, stuffDefeat, crcInvert, fillSel}
  localparam int NVEC = 7;
  localparam logic [24:0] VECS [0:NVEC-1] = '{
    {5'd3, 8'h12, 8'h11, 4'b0000},   // plain frame
    {5'd4, 8'hFF, 8'h00, 4'b0000},   // stuffing heavy
    {5'd4, 8'hFF, 8'h00, 4'b0100},   // stuffing off
    {5'd2, 8'hA5, 8'h3C, 4'b1000},   // no check sequence
    {5'd2, 8'hA5, 8'h3C, 4'b1010},   // invert ignored when defeated
    {5'd3, 8'h01, 8'h7E, 4'b0010},   // inverted check sequence
    {5'd5, 8'hF0, 8'h0F, 4'b0001}    // idle fill
  };

  initial begin
    bit b, pe;
    int errs, firstBad, peCount, peIdx;
    logic [15:0] crc;

    repeat (3) tick();
    // Reset state: R11 R1 R7 R10 R9
    chk(txBit == 1'b1, "R11 reset txBit", txBit, 1);
    chk(fillLevel == 0, "R1 reset fillLevel", fillLevel, 0);
    chk(underrun == 1'b0 && overflow == 1'b0, "R7 reset flags", {underrun, overflow}, 0);
    chk(pktEnd == 1'b0, "R9 reset pktEnd", pktEnd, 0);
    rst_n = 1'b1;
    tick();
    chk(lowMark == 1'b1, "R10 empty below mark", lowMark, 1);

    // Frame vectors: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NVEC; v++) begin
      logic [4:0] len;
      logic [7:0] base, step, d;
      len  = VECS[v][24:20];
      base = VECS[v][19:12];
      step = VECS[v][11:4];
      crcDefeat   = VECS[v][3];
      stuffDefeat = VECS[v][2];
      crcInvert   = VECS[v][1];
      fillSel     = VECS[v][0];
      doTxReset();
      expN = 0; runOnes = 0; crc = 16'hFFFF;
      pushRaw(8'h7E);
      pushRaw(8'h7E);
      d = base;
      for (int i = 0; i < int'(len); i++) begin
        writeByte(d, i == int'(len) - 1);
        crc = modelCrc(crc, d);
        pushStuffed(d, stuffDefeat);
        d = d + step;
      end
      if (!crcDefeat) begin
        if (!crcInvert) crc = ~crc;
        pushStuffed(crc[7:0], stuffDefeat);
        pushStuffed(crc[15:8], stuffDefeat);
      end
      pushRaw(8'h7E);
      closeEnd = expN - 1;
      pushRaw(fillSel ? 8'hFF : 8'h7E);
      pushRaw(fillSel ? 8'hFF : 8'h7E);
      chk(fillLevel == 9'(len), "R1 level after writes", fillLevel, len);
      errs = 0; firstBad = -1; peCount = 0; peIdx = -1;
      for (int i = 0; i < expN; i++) begin
        sendBit(b, pe);
        if (b != expBits[i]) begin
          errs++;
          if (firstBad < 0) firstBad = i;
        end
        if (pe) begin
          peCount++;
          if (peIdx < 0) peIdx = i;
        end
      end
      if (errs != 0)
        $display("vector %0d first mismatch at bit %0d", v, firstBad);
      chk(errs == 0, $sformatf("R2 R3 R4 R5 R6 stream vector %0d mismatches", v), errs, 0);
      chk(peCount == 1 && peIdx == closeEnd, $sformatf("R9 pktEnd position vector %0d", v), peIdx, closeEnd);
      chk(fillLevel == 0 && underrun == 1'b0, $sformatf("R1 drained vector %0d", v), fillLevel, 0);
    end

    // R11: no strobe, no line change
    crcDefeat = 0; stuffDefeat = 0; crcInvert = 0; fillSel = 0;
    doTxReset();
    writeByte(8'h01, 1'b1);
    begin
      logic held;
      held = txBit;
      errs = 0;
      repeat (20) begin tick(); if (txBit != held) errs++; end
      chk(errs == 0, "R11 txBit holds without bitEn", errs, 0);
    end

    // R10 watermark thresholds
    doTxReset();
    lowMarkSel = 3'd0;
    for (int i = 0; i < 31; i++) writeByte(8'(i), 1'b0);
    chk(lowMark == 1'b1, "R10 31 below 32", lowMark, 1);
    writeByte(8'h00, 1'b0);
    chk(lowMark == 1'b0, "R10 32 not below 32", lowMark, 0);
    lowMarkSel = 3'd1; tick();
    chk(lowMark == 1'b1, "R10 32 below 64", lowMark, 1);
    lowMarkSel = 3'd7; tick();
    chk(lowMark == 1'b1, "R10 32 below 256", lowMark, 1);

    // R1 overflow
    for (int i = 32; i < 256; i++) writeByte(8'(i), 1'b0);
    chk(fillLevel == 256 && overflow == 1'b0, "R1 full no overflow", {overflow, fillLevel}, 256);
    chk(lowMark == 1'b0, "R10 full not below 256", lowMark, 0);
    writeByte(8'hAA, 1'b1);
    chk(fillLevel == 256, "R1 write to full dropped", fillLevel, 256);
    chk(overflow == 1'b1, "R1 overflow set", overflow, 1);
    repeat (4) tick();
    chk(overflow == 1'b1, "R1 overflow sticky", overflow, 1);
    doTxReset();
    chk(fillLevel == 0 && overflow == 1'b0, "R8 txReset clears queue", {overflow, fillLevel}, 0);
    lowMarkSel = 3'd0;

    // R7 underrun then R8 fill-only
    writeByte(8'h00, 1'b0);
    writeByte(8'h00, 1'b0);
    expN = 0;
    pushRaw(8'h7E); pushRaw(8'h7E); pushRaw(8'h00); pushRaw(8'h00);
    pushRaw(8'hFE); pushRaw(8'h7E); pushRaw(8'h7E);
    errs = 0;
    for (int i = 0; i < expN; i++) begin
      sendBit(b, pe);
      if (b != expBits[i]) errs++;
    end
    chk(errs == 0, "R7 abort then fill stream", errs, 0);
    chk(underrun == 1'b1, "R7 underrun set", underrun, 1);
    writeByte(8'h01, 1'b1);
    errs = 0; peCount = 0;
    for (int i = 0; i < 32; i++) begin
      sendBit(b, pe);
      if (b != ((8'h7E >> (i % 8)) & 1)) errs++;
      if (pe) peCount++;
    end
    chk(errs == 0 && peCount == 0, "R8 fill only after underrun", errs, 0);
    chk(fillLevel == 1, "R8 queue not drained after underrun", fillLevel, 1);
    chk(underrun == 1'b1, "R7 underrun sticky", underrun, 1);
    doTxReset();
    chk(underrun == 1'b0 && fillLevel == 0, "R8 txReset clears underrun", {underrun, fillLevel}, 0);
    chk(txBit == 1'b1, "R11 txReset restores idle line", txBit, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule